// File: doc/BRIEF.md
# Synchronous Serial Byte Port

This block moves one byte at a time over a three-wire synchronous serial link (clock, data out, data in). A processor controls it through three byte registers on a simple bus: a control register, a status register and a data register. When the processor writes a byte to the data register in master mode, the block produces the serial clock from the system clock and shifts the byte out. At the same time it shifts a byte in, then raises a completion flag. The flag can drive an interrupt line.

In slave mode the block does not drive the serial clock. It follows an external clock, which is synchronised into the system clock domain, and shifts on its edges. The control register chooses the bit order and the clock rate. It also gates the interrupt and gives a write-only way to clear the flags. When the port is disabled, the serial pins are idle and any transfer is abandoned.

Top module: `sync_serial_port`

## Requirements
- R1: The control register sits at offset 0x0A, status at 0x0B and data at 0x0C. Control bits 7..0 are: interrupt enable, port enable, LSB-first, master, flag reset, clock phase, rate bit 1, rate bit 0. All bits reset to 0, bit 3 always reads 0, and status and data read 0 after reset.
- R2: In master mode the serial clock idles low. The rate field (bits 1:0) gives a half period of H = 2, 4, 8 or 16 system clocks for codes 0, 1, 2 and 3. The clock first rises H clocks after the write to the data register, and the completion flag is set 16*H clocks after that write.
- R3: During a transfer the first bit appears on the data output when the transfer starts, and the output changes only when the serial clock falls. Input data is sampled when the serial clock rises.
- R4: With LSB-first at 0, data bit 7 is sent first. With it at 1, bit 0 is sent first.
- R5: When the eighth bit has been shifted, status bit 7 (completion flag) is set and the data register reads the received byte. The first received bit lands in bit 7 for MSB-first order and in bit 0 for LSB-first order. The data register changes at no other time.
- R6: The interrupt output is high exactly when the interrupt enable bit and the completion flag are both 1.
- R7: A control write that clears interrupt enable, with the flag reset bit at 0, leaves the completion flag unchanged.
- R8: A control write with bit 3 at 1 clears the completion flag and the write-collision bit.
- R9: A data register write during a transfer is ignored and sets status bit 6 (write collision). The transfer in progress continues with its original byte.
- R10: A control write with port enable at 0 ends any transfer at once. The serial clock and data output stay 0, and no completion flag follows.
- R11: In slave mode the serial clock output stays 0. The block shifts on the external clock: it samples on rising edges and shifts out on falling edges. It sets the completion flag after the eighth falling edge.
- R12: A data register write while the port is disabled starts nothing and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | External serial clock used in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A register write takes effect at the clock edge where it is sampled and shows on the outputs in the following cycle. In master mode the serial clock toggles every H clocks after that edge. The flag and the received byte follow the write edge by exactly 16*H clocks. In slave mode an external clock edge acts on the third system clock edge after it changes, because it passes through two synchroniser stages and an edge detector. The reference model in the bench steps through the same edge count from its own timers and a queue of past external clock samples. Outputs are compared every cycle half a period after the active edge, and the flag latency is measured in cycles for two rates.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h0A,
  parameter logic [ADDR_W-1:0] STS_OFS = 'h0B,
  parameter logic [ADDR_W-1:0] DAT_OFS = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              sdo,
  input  logic              sdi
);
  localparam int BITS = 8;
  localparam int BC_W = $clog2(BITS + 1);
  localparam int HC_W = 5;

  logic ie_q, en_q, lsb_q, mst_q, pha_q;
  logic [1:0] rate_q;
  logic flag_q, wcol_q, busy_q, sck_q, samp_q;
  logic [7:0] sr_q, rx_q;
  logic [HC_W-1:0] hc_q;
  logic [BC_W-1:0] bc_q;
  logic [2:0] ss_q;

  wire wr_ctl = bus_sel & bus_wr & (bus_addr == CTL_OFS);
  wire wr_dat = bus_sel & bus_wr & (bus_addr == DAT_OFS);

  logic [HC_W-1:0] half_m1;
  assign half_m1 = (HC_W'(2) << rate_q) - HC_W'(1);

  wire tick   = busy_q & mst_q & (hc_q == half_m1);
  wire s_rise = busy_q & ~mst_q & ss_q[1] & ~ss_q[2];
  wire s_fall = busy_q & ~mst_q & ~ss_q[1] & ss_q[2];
  wire rise   = (tick & ~sck_q) | s_rise;
  wire fall   = (tick & sck_q) | s_fall;
  wire last   = fall & (bc_q == BC_W'(BITS - 1));
  wire start  = wr_dat & en_q & ~busy_q;
  wire abort  = wr_ctl & ~bus_wdata[6];

  logic [7:0] sr_next;
  assign sr_next = lsb_q ? {samp_q, sr_q[7:1]} : {sr_q[6:0], samp_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ie_q, en_q, lsb_q, mst_q, pha_q} <= '0;
      rate_q <= '0;
    end else if (wr_ctl) begin
      {ie_q, en_q, lsb_q, mst_q} <= bus_wdata[7:4];
      pha_q  <= bus_wdata[2];
      rate_q <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      if (last) flag_q <= 1'b1;
      else if (wr_ctl && bus_wdata[3]) flag_q <= 1'b0;
      if (wr_dat && en_q && busy_q) wcol_q <= 1'b1;
      else if (wr_ctl && bus_wdata[3]) wcol_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hc_q   <= '0;
      sck_q  <= 1'b0;
      samp_q <= 1'b0;
      sr_q   <= '0;
      bc_q   <= '0;
      rx_q   <= '0;
      ss_q   <= '0;
    end else begin
      ss_q <= {ss_q[1:0], sck_i};
      if (abort) busy_q <= 1'b0;
      else if (start) busy_q <= 1'b1;
      else if (last) busy_q <= 1'b0;
      if (start || tick) hc_q <= '0;
      else if (busy_q) hc_q <= hc_q + HC_W'(1);
      if (start || abort) sck_q <= 1'b0;
      else if (tick) sck_q <= ~sck_q;
      if (rise) samp_q <= sdi;
      if (start) begin
        sr_q <= bus_wdata;
        bc_q <= '0;
      end else if (fall) begin
        sr_q <= sr_next;
        bc_q <= bc_q + BC_W'(1);
      end
      if (last) rx_q <= sr_next;
    end
  end

  assign sck_o = busy_q & mst_q & sck_q;
  assign sdo   = busy_q & en_q & (lsb_q ? sr_q[0] : sr_q[7]);
  assign irq   = ie_q & flag_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == CTL_OFS)      bus_rdata = {ie_q, en_q, lsb_q, mst_q, 1'b0, pha_q, rate_q};
    else if (bus_addr == STS_OFS) bus_rdata = {flag_q, wcol_q, 6'b0};
    else if (bus_addr == DAT_OFS) bus_rdata = rx_q;
  end

  AST_SCK_LOW_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && !sck_o)); // R2
  AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && sck_o && $past(sck_o)) |-> $stable(sdo)); // R3
  AST_RX_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(rx_q)); // R5
  AST_IE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !bus_wdata[3] && !last) |=> (flag_q == $past(flag_q))); // R7
  AST_FLAG_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[3] && !last) |=> !flag_q); // R8
  AST_WCOL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && en_q && busy_q) |=> wcol_q); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy_q && !sck_o && !sdo)); // R10
endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sel = 0, wr = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic irq, sck_o, sdo, sdi;
  logic sck_i = 0, sdi_s = 0, loop = 0, use_lfsr = 0;
  logic [7:0] lfsr = 8'h5A;
  assign sdi = loop ? sdo : (use_lfsr ? lfsr[0] : sdi_s);

  sync_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .sck_o(sck_o),
    .sck_i(sck_i), .sdo(sdo), .sdi(sdi)
  );

  int nvec = 0, nfail = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model
  logic [7:0] m_ctl = 0, m_tx = 0, m_acc = 0, m_rx = 0;
  bit m_flag = 0, m_wcol = 0, m_busy = 0;
  int m_t = 0, m_idx = 0;
  bit hq[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_flag = 0; m_wcol = 0; m_busy = 0; m_rx = 0; m_t = 0; m_idx = 0;
      hq = '{0, 0, 0};
    end else begin
      bit ob, rise, fall, done;
      int h, tn;
      ob = m_busy; rise = 0; fall = 0; done = 0;
      h = 2 << m_ctl[1:0];
      tn = m_t + 1;
      if (m_busy && m_ctl[4]) begin
        rise = (tn % (2 * h)) == h;
        fall = (tn % (2 * h)) == 0;
        m_t = tn;
      end else if (m_busy) begin
        rise = hq[1] && !hq[0];
        fall = !hq[1] && hq[0];
      end
      if (rise) m_acc[m_ctl[5] ? m_idx : 7 - m_idx] = sdi;
      if (fall) begin
        m_idx++;
        if (m_idx == 8) begin m_busy = 0; m_flag = 1; m_rx = m_acc; done = 1; end
      end
      hq.push_back(sck_i);
      void'(hq.pop_front());
      if (sel && wr && addr == 8'h0C && m_ctl[6]) begin
        if (ob) m_wcol = 1;
        else begin m_busy = 1; m_tx = wdata; m_t = 0; m_idx = 0; m_acc = 0; end
      end
      if (sel && wr && addr == 8'h0A) begin
        m_ctl = wdata & 8'hF7;
        if (wdata[3]) begin
          m_wcol = 0;
          if (!done) m_flag = 0;
        end
        if (!wdata[6]) m_busy = 0;
      end
    end
  end

  logic sck_prev = 0;
  logic [7:0] cap = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      int h;
      logic e_sck, e_sdo;
      logic [7:0] e_rd;
      string t;
      h = 2 << m_ctl[1:0];
      e_sck = (m_busy && m_ctl[4]) ? ((m_t / h) % 2 == 1) : 1'b0;
      e_sdo = m_busy ? m_tx[m_ctl[5] ? m_idx : 7 - m_idx] : 1'b0;
      e_rd = (addr == 8'h0A) ? m_ctl : (addr == 8'h0B) ? {m_flag, m_wcol, 6'b0} :
             (addr == 8'h0C) ? m_rx : 8'h00;
      t = (addr == 8'h0A) ? "R1" : (addr == 8'h0B) ? "R5 R9 status" : "R5 data";
      chk("R2 sck", {7'b0, sck_o}, {7'b0, e_sck});
      chk("R3 R4 sdo", {7'b0, sdo}, {7'b0, e_sdo});
      chk("R6 irq", {7'b0, irq}, {7'b0, m_ctl[7] & m_flag});
      chk(t, rdata, e_rd);
      if (sck_o && !sck_prev) cap = {cap[6:0], sdo};
      sck_prev = sck_o;
    end
  end

  always @(negedge clk) begin
    #1 lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1 sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); #1 sel = 0; wr = 0; addr = 8'h0B;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); #1 addr = a; #1 v = rdata;
  endtask

  task automatic xfer_timed(input logic [7:0] d, input int expc);
    int n;
    wr_reg(8'h0C, d);
    n = 1;
    while (!rdata[7]) begin @(negedge clk); #1; n++; end
    chk("R2 flag latency", 8'(n), 8'(expc));
  endtask

  task automatic wait_flag();
    @(negedge clk); #1 addr = 8'h0B;
    #1 while (!rdata[7]) begin @(negedge clk); #2; end
  endtask

  logic [7:0] caps = 0;
  task automatic slave_byte(input logic [7:0] din, input bit lsb);
    for (int i = 0; i < 8; i++) begin
      sdi_s = lsb ? din[i] : din[7 - i];
      repeat (6) @(negedge clk);
      #1 caps = {caps[6:0], sdo}; sck_i = 1;
      repeat (6) @(negedge clk);
      #1 sck_i = 0;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v, keep;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    rd(8'h0A, v); chk("R1 ctl reset", v, 8'h00);
    rd(8'h0B, v); chk("R1 sts reset", v, 8'h00);
    rd(8'h0C, v); chk("R1 dat reset", v, 8'h00);
    chk("R1 pins reset", {5'b0, irq, sck_o, sdo}, 8'h00);

    // master, MSB first, rate 0, loopback
    wr_reg(8'h0A, 8'h50); loop = 1; cap = 0;
    xfer_timed(8'h1E, 16 * 2 + 1);
    chk("R4 msb order", cap, 8'h1E);
    rd(8'h0C, v); chk("R5 rx byte", v, 8'h1E);
    rd(8'h0B, v); chk("R5 flag", v, 8'h80);
    chk("R6 irq gated", {7'b0, irq}, 8'h00);
    wr_reg(8'h0A, 8'hD0); chk("R6 irq on", {7'b0, irq}, 8'h01);
    wr_reg(8'h0A, 8'h50);
    rd(8'h0B, v); chk("R7 flag kept", v, 8'h80);
    chk("R7 irq off", {7'b0, irq}, 8'h00);
    wr_reg(8'h0A, 8'h58);
    rd(8'h0B, v); chk("R8 flag cleared", v, 8'h00);
    rd(8'h0A, v); chk("R1 reset bit reads 0", v, 8'h50);

    // LSB first, rate 3, collision
    loop = 0; use_lfsr = 1;
    wr_reg(8'h0A, 8'h73); cap = 0;
    wr_reg(8'h0C, 8'h1E);
    repeat (40) @(negedge clk);
    wr_reg(8'h0C, 8'h55);
    rd(8'h0B, v); chk("R9 wcol set", v, 8'h40);
    wait_flag();
    chk("R4 lsb order R9 byte kept", cap, 8'h78);
    rd(8'h0B, v); chk("R9 flag and wcol", v, 8'hC0);
    wr_reg(8'h0A, 8'h7B);
    rd(8'h0B, v); chk("R8 wcol cleared", v, 8'h00);

    // rate 1 latency
    wr_reg(8'h0A, 8'h51);
    xfer_timed(8'hA7, 16 * 4 + 1);
    wr_reg(8'h0A, 8'h59);

    // abort
    rd(8'h0C, keep);
    wr_reg(8'h0A, 8'h52);
    wr_reg(8'h0C, 8'hF0);
    repeat (20) @(negedge clk);
    wr_reg(8'h0A, 8'h12);
    chk("R10 pins idle", {6'b0, sck_o, sdo}, 8'h00);
    repeat (300) @(negedge clk);
    rd(8'h0B, v); chk("R10 no flag", v, 8'h00);
    rd(8'h0C, v); chk("R10 data kept", v, keep);

    // write while disabled
    wr_reg(8'h0C, 8'h99);
    repeat (100) @(negedge clk);
    rd(8'h0B, v); chk("R12 no flag", v, 8'h00);
    rd(8'h0C, v); chk("R12 data kept", v, keep);
    wr_reg(8'h0A, 8'h52);
    repeat (150) @(negedge clk);
    rd(8'h0B, v); chk("R12 nothing latched", v, 8'h00);
    chk("R12 sck idle", {7'b0, sck_o}, 8'h00);

    // slave, MSB first
    use_lfsr = 0;
    wr_reg(8'h0A, 8'h40);
    wr_reg(8'h0C, 8'hC3);
    caps = 0;
    slave_byte(8'h6A, 0);
    chk("R11 slave tx", caps, 8'hC3);
    rd(8'h0C, v); chk("R11 slave rx", v, 8'h6A);
    rd(8'h0B, v); chk("R11 slave flag", v, 8'h80);

    // slave, LSB first
    wr_reg(8'h0A, 8'h68);
    wr_reg(8'h0C, 8'h35);
    caps = 0;
    slave_byte(8'h6A, 1);
    chk("R11 R4 slave lsb tx", caps, 8'hAC);
    rd(8'h0C, v); chk("R11 slave lsb rx", v, 8'h6A);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule